// File: doc/BRIEF.md
# GPIO edge/level interrupt aggregator

This block is the interrupt logic of a GPIO port with up to 32 lines. It receives the line vector with polarity already applied. Each low-to-high transition of a line sets a bit in a shared, sticky edge-cause register. Two processors each own an edge mask and a level mask. For processor n, the active vector is the level-masked live input OR-ed with the edge-masked cause bits. That vector is reduced in groups of eight lines, giving one registered, active-high interrupt per group per processor.

Software reaches the cause and mask registers through a simple single-cycle register port. The cause register is cleared by writing zero to a bit: bits written as 1 keep their value. To acknowledge one line, software writes all ones except that line's bit. A pin that must report falling edges is handled upstream by inverting its polarity, so this block only ever detects rising transitions.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset every cause and mask register reads 0, `irq_o` is all zero and `rdata_o` is 0.
- R2: The register map is: edge cause at 0x14, processor 0 edge mask at 0x18, processor 0 level mask at 0x1C, processor 1 edge mask at 0x30 and processor 1 level mask at 0x34. A read (`req_i`=1, `we_i`=0) loads `rdata_o` at the next clock edge. Any other address reads 0. `rdata_o` holds its value when there is no read.
- R3: When line i is 0 in one cycle and 1 in the next, cause bit i is set at the following clock edge. The previous-sample register resets to 0.
- R4: A cause bit stays set when its line falls again. It is cleared only by a cause write.
- R5: A write to 0x14 clears each cause bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged.
- R6: If a new rising transition on line i arrives in the same cycle as a write that clears bit i, the bit ends set.
- R7: A level-masked line produces its interrupt one clock after the input is sampled.
- R8: An edge-masked cause bit produces its interrupt one clock after the cause register holds it. With every mask at 0, no interrupt is raised.
- R9: `irq_o[n*4+g]` is the OR of the active bits of lines 8g through 8g+7 for processor n.
- R10: Both processors see the same cause register, but each one's output is gated only by its own masks.
- R11: A write to a mask address stores the full data word, and the word reads back at the same address. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 32 | Polarity-corrected line vector |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after a read request |
| irq_o | output | 8 | Grouped interrupts, bit n*4+g for processor n and group g |

## Verification
A new rising transition on a line can arrive in the same cycle as a cause write that clears that line's bit. The directed sequence provokes this by raising line 9 in the exact cycle of a clear of bit 9. The random phase also provokes it, mixing frequent single-bit clear writes with toggling lines. A behavioural model updated on every clock judges the result: the set must win, both in the read-back of 0x14 and in the edge interrupts of both processors.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned BUS_W  = 32;
  localparam logic [REG_AW-1:0] CAUSE_ADDR = 8'h14;

  // processor 0 sits in the base window, later processors in an 8-byte stride at 0x30
  function automatic logic [REG_AW-1:0] edge_mask_addr(int unsigned cpu);
    return (cpu == 0) ? 8'h18 : 8'(32'h30 + (cpu - 1) * 8);
  endfunction

  function automatic logic [REG_AW-1:0] level_mask_addr(int unsigned cpu);
    return (cpu == 0) ? 8'h1C : 8'(32'h34 + (cpu - 1) * 8);
  endfunction
endpackage

// File: rtl/gpio_edge_cause.sv
`timescale 1ns/1ps
module gpio_edge_cause #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 clr_we_i,
  input  logic [NUM_LINES-1:0] clr_data_i,
  output logic [NUM_LINES-1:0] cause_o
);
  logic [NUM_LINES-1:0] prev_q, cause_q, rise, keep;

  assign rise = lines_i & ~prev_q;
  assign keep = clr_we_i ? clr_data_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= lines_i;
      cause_q <= (cause_q & keep) | rise;  // set beats clear
    end
  end

  assign cause_o = cause_q;

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((cause_q & ~$past(clr_data_i) & ~$past(rise)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((cause_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/gpio_cpu_irq.sv
`timescale 1ns/1ps
module gpio_cpu_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned GROUP_W   = 8,
  parameter int unsigned CPU_ID    = 0,
  localparam int unsigned NUM_GRP  = NUM_LINES / GROUP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [NUM_LINES-1:0] cause_i,
  output logic [NUM_LINES-1:0] edge_mask_o,
  output logic [NUM_LINES-1:0] level_mask_o,
  output logic [NUM_GRP-1:0]   irq_o
);
  localparam logic [REG_AW-1:0] EDGE_A  = edge_mask_addr(CPU_ID);
  localparam logic [REG_AW-1:0] LEVEL_A = level_mask_addr(CPU_ID);

  logic [NUM_LINES-1:0] edge_q, level_q, active;
  logic [NUM_GRP-1:0]   irq_d, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q  <= '0;
      level_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == EDGE_A)  edge_q  <= wdata_i;
      if (addr_i == LEVEL_A) level_q <= wdata_i;
    end
  end

  assign active = (lines_i & level_q) | (cause_i & edge_q);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign irq_d[g] = |active[g*GROUP_W +: GROUP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign edge_mask_o  = edge_q;
  assign level_mask_o = level_q;
  assign irq_o        = irq_q;

  assert_level_fires_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lines_i & level_q) != '0) |=> (irq_o != '0));

  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_q == '0 && level_q == '0) |=> (irq_o == '0));
endmodule

// File: rtl/gpio_irq_agg.sv
`timescale 1ns/1ps
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned GROUP_W   = 8,
  parameter int unsigned NUM_CPUS  = 2,
  localparam int unsigned NUM_GRP  = NUM_LINES / GROUP_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_LINES-1:0]          lines_i,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [BUS_W-1:0]              wdata_i,
  output logic [BUS_W-1:0]              rdata_o,
  output logic [NUM_CPUS*NUM_GRP-1:0]   irq_o
);
  logic                 wr_en, rd_en, cause_we;
  logic [NUM_LINES-1:0] wdata_l, cause;
  logic [NUM_LINES-1:0] edge_m  [NUM_CPUS];
  logic [NUM_LINES-1:0] level_m [NUM_CPUS];
  logic [BUS_W-1:0]     rd_val, rdata_q;

  assign wr_en    = req_i & we_i;
  assign rd_en    = req_i & ~we_i;
  assign cause_we = wr_en && (addr_i == CAUSE_ADDR);
  assign wdata_l  = wdata_i[NUM_LINES-1:0];

  gpio_edge_cause #(.NUM_LINES(NUM_LINES)) i_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lines_i    (lines_i),
    .clr_we_i   (cause_we),
    .clr_data_i (wdata_l),
    .cause_o    (cause)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    gpio_cpu_irq #(
      .NUM_LINES (NUM_LINES),
      .GROUP_W   (GROUP_W),
      .CPU_ID    (c)
    ) i_cpu (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en),
      .addr_i       (addr_i),
      .wdata_i      (wdata_l),
      .lines_i      (lines_i),
      .cause_i      (cause),
      .edge_mask_o  (edge_m[c]),
      .level_mask_o (level_m[c]),
      .irq_o        (irq_o[c*NUM_GRP +: NUM_GRP])
    );
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == CAUSE_ADDR) rd_val = BUS_W'(cause);
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (addr_i == edge_mask_addr(unsigned'(c)))  rd_val = BUS_W'(edge_m[c]);
      if (addr_i == level_mask_addr(unsigned'(c))) rd_val = BUS_W'(level_m[c]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_o));
endmodule

// File: tb/test_gpio_irq_agg.sv
`timescale 1ns/1ps
module test_gpio_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lines;
  logic        req, we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  irq;

  always #2.5 clk = ~clk;

  gpio_irq_agg i_gpio_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int    compared = 0, mismatched = 0;
  bit    done = 0;
  string phase = "R1";

  logic [31:0] m_cause, m_prev, m_rdata;
  logic [31:0] m_em [2];
  logic [31:0] m_lm [2];
  logic [7:0]  m_irq;

  task automatic model_reset();
    m_cause = 0; m_prev = 0; m_rdata = 0; m_irq = 0;
    m_em[0] = 0; m_em[1] = 0; m_lm[0] = 0; m_lm[1] = 0;
  endtask

  task automatic model_step();
    logic [31:0] rise, keep, act;
    logic [7:0]  ni;
    rise = lines & ~m_prev;
    for (int c = 0; c < 2; c++) begin
      act = (lines & m_lm[c]) | (m_cause & m_em[c]);
      for (int g = 0; g < 4; g++) ni[c*4+g] = |act[g*8 +: 8];
    end
    if (req && !we) begin
      case (addr)
        8'h14:   m_rdata = m_cause;
        8'h18:   m_rdata = m_em[0];
        8'h1C:   m_rdata = m_lm[0];
        8'h30:   m_rdata = m_em[1];
        8'h34:   m_rdata = m_lm[1];
        default: m_rdata = 0;
      endcase
    end
    keep = (req && we && addr == 8'h14) ? wdata : 32'hFFFF_FFFF;
    m_cause = (m_cause & keep) | rise;
    if (req && we) begin
      case (addr)
        8'h18:   m_em[0] = wdata;
        8'h1C:   m_lm[0] = wdata;
        8'h30:   m_em[1] = wdata;
        8'h34:   m_lm[1] = wdata;
        default: ;
      endcase
    end
    m_prev = lines;
    m_irq  = ni;
  endtask

  task automatic compare();
    compared++;
    if (rdata !== m_rdata || irq !== m_irq) begin
      mismatched++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               phase, rdata, irq, m_rdata, m_irq);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    cycle();
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    req = 1; we = 0; addr = a;
    cycle();
    req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic read_all();
    rd(8'h14); rd(8'h18); rd(8'h1C); rd(8'h30); rd(8'h34);
  endtask

  initial begin
    logic [7:0] amap [7];
    amap = '{8'h14, 8'h18, 8'h1C, 8'h30, 8'h34, 8'h20, 8'h24};
    rst_n = 0; lines = 0; req = 0; we = 0; addr = 0; wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    phase = "R1"; compare();           // reset state at the ports
    rst_n = 1;
    read_all();

    phase = "R11";
    wr(8'h18, 32'h0000_00F1); wr(8'h1C, 32'h0F00_0000);
    wr(8'h30, 32'hA5A5_0000); wr(8'h34, 32'h0000_5A5A);
    read_all();
    wr(8'h24, 32'hFFFF_FFFF);          // unmapped write must not land anywhere
    read_all();
    phase = "R2";
    rd(8'h20); idle(2); rd(8'h18); idle(1);
    wr(8'h18, 0); wr(8'h1C, 0); wr(8'h30, 0); wr(8'h34, 0);

    phase = "R3";
    lines = 32'h8000_0201; idle(1); rd(8'h14);
    phase = "R4";
    lines = 0; idle(2); rd(8'h14);
    phase = "R5";
    wr(8'h14, ~32'h0000_0001); rd(8'h14);
    wr(8'h14, 32'h0); rd(8'h14);

    phase = "R6";
    lines = 0; idle(1);
    lines = 32'h0000_0200; wr(8'h14, ~32'h0000_0200); rd(8'h14);
    wr(8'h18, 32'h0000_0200); idle(2);
    lines = 0; wr(8'h14, 0); idle(2);
    wr(8'h18, 0);

    phase = "R7";
    wr(8'h1C, 32'hFFFF_FFFF);
    for (int b = 0; b < 32; b += 5) begin lines = 32'h1 << b; idle(1); end
    lines = 0; idle(2);
    wr(8'h1C, 0); wr(8'h14, 0);

    phase = "R8";
    wr(8'h18, 32'h0001_0000);
    lines = 32'h0001_0000; idle(1); lines = 0; idle(3);
    wr(8'h14, ~32'h0001_0000); idle(2);
    wr(8'h18, 0); wr(8'h14, 0);

    phase = "R9";
    wr(8'h1C, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    for (int g = 0; g < 4; g++) begin
      lines = 32'h80 << (g*8); idle(2);
      lines = 32'h01 << (g*8); idle(2);
    end
    lines = 0; idle(2);
    wr(8'h1C, 0); wr(8'h34, 0); wr(8'h14, 0);

    phase = "R10";
    wr(8'h18, 32'h0000_00FF); wr(8'h30, 32'hFF00_0000);
    lines = 32'h0100_0004; idle(1); lines = 0; idle(3);
    wr(8'h14, ~32'h0000_0004); idle(2);
    wr(8'h14, 0); idle(2);

    phase = "R6 R5 random";
    for (int i = 0; i < 3000; i++) begin
      lines = lines ^ ($urandom() & $urandom() & $urandom());
      req = ($urandom_range(0, 2) != 0);
      we  = $urandom_range(0, 1);
      addr = amap[$urandom_range(0, 6)];
      if ($urandom_range(0, 1) != 0) begin
        addr = 8'h14;
        wdata = ~(32'h1 << $urandom_range(0, 31));
      end else wdata = $urandom();
      cycle();
    end
    req = 0; we = 0; idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog (%s): actual=hung expected=finished", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule